// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one read or write command into the stream of column addresses that a synchronous DRAM burst visits. It produces one address per clock. A command carries a start column. Mode inputs are sampled with that command: a burst-length code, an ordering select (linear wrap or XOR interleave) and a read-latency select. For read bursts the block also produces a data-valid strobe. The strobe trails each read beat by the selected latency of two or three clocks, so a capture stage can pick data off the memory bus.

A burst can be cut short with a terminate command. A new read or write command can replace it on any clock, with no spacing rule between commands. Read beats that were already issued still produce their data-valid pulses. A full-page burst sweeps every column of the page, wrapping at the top, until a command stops or replaces it. If a mode combination has no defined meaning, the block raises an error flag and issues a single beat.

The column stream has no ready input, and the block does not accept back-pressure. The memory array cannot be paused in the middle of a burst, so the consumer must take the beat on every cycle that `col_valid` is high. All inputs are sampled on the rising clock edge, and every output changes only on that edge.

Top module: `burst_colseq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `col_valid`, `rd_valid` and `mode_err` are low.
- R2: A read (`cmd_code`=01) or write (`cmd_code`=10) sampled at an edge makes `col_valid` high after that edge, with `col_addr` equal to the sampled `start_col`. `col_is_read` is 1 for a read and 0 for a write.
- R3: Linear ordering (`interleave`=0) with length BL: beat k has address bits above log2(BL) equal to those of the start column, and low bits equal to (start low bits + k) mod BL.
- R4: Interleaved ordering (`interleave`=1): beat k has address start_col XOR k, for k < BL.
- R5: `bl_code` 000, 001, 010 and 011 select BL of 1, 2, 4 and 8. The burst issues exactly BL beats on consecutive cycles, and `col_valid` then falls unless a new command arrives.
- R6: `bl_code`=111 with linear ordering is full page. The address increases by one per cycle modulo 2^COL_W (the value after 511 is 0), and the burst never ends by itself.
- R7: `bl_code` of 100, 101 or 110, or `bl_code`=111 with `interleave`=1, sets `mode_err` after the command edge and yields exactly one beat. `mode_err` keeps its value until the next read or write command and is then updated.
- R8: A terminate (`cmd_code`=11) sampled at an edge makes `col_valid` low after that edge. A terminate while idle has no effect.
- R9: A read or write arriving during a burst restarts the sequence at once from the new start column and mode, whatever beat the old burst had reached.
- R10: Each read beat issued after edge E produces `rd_valid` high after edge E+CL. CL is 2 when `lat3`=0 and 3 when `lat3`=1, as sampled with the beat's command. Read beats already issued complete this way even after a terminate or interrupt.
- R11: Write beats never produce `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 2 | 00 none, 01 read, 10 write, 11 terminate |
| start_col | input | COL_W | Start column for a read or write |
| bl_code | input | 3 | Burst-length code |
| interleave | input | 1 | 1 selects XOR interleaved ordering |
| lat3 | input | 1 | Read latency select: 0 gives 2 clocks, 1 gives 3 |
| col_valid | output | 1 | A column beat is present this cycle |
| col_addr | output | COL_W | Column address of the current beat |
| col_is_read | output | 1 | Current beat belongs to a read |
| rd_valid | output | 1 | Read data is expected on the bus this cycle |
| mode_err | output | 1 | Last command carried an undefined mode |

## Verification
The bench builds the block with its default COL_W of 9, which gives a 512-column page. With this width, a full-page burst started near the top of the page crosses the wrap from 511 to 0 within a few hundred cycles. At the same width, the short bursts exercise both orderings with start columns that are not aligned, so the wrap inside an aligned block is visible. Both latency settings are used, and bursts are terminated and interrupted while read beats are still in the latency pipe, so the trailing strobes can be seen after the column stream has stopped.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_TERM  = 2'b11
  } colseq_cmd_e;

  typedef struct packed {
    logic live;
    logic lat3;
  } rd_tag_t;

  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 3;
endpackage

// File: rtl/colseq_mode_dec.sv
module colseq_mode_dec #(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  output logic [COL_W-1:0] len_mask,
  output logic             full_page,
  output logic             bad_mode
);
  always_comb begin
    len_mask  = '0;
    full_page = 1'b0;
    bad_mode  = 1'b0;
    case (bl_code)
      3'b000, 3'b001, 3'b010, 3'b011:
        len_mask = (COL_W'(1) << bl_code) - COL_W'(1);
      3'b111: begin
        if (interleave) begin
          bad_mode = 1'b1;
        end else begin
          full_page = 1'b1;
          len_mask  = '1;
        end
      end
      default: bad_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] len_mask,
  input  logic             full_page,
  input  logic             interleave,
  input  logic             is_read,
  input  logic             lat3,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_is_read,
  output logic             col_lat3
);
  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             rd_q;
  logic             lat3_q;
  logic             last_beat;
  logic [COL_W-1:0] linear_sum;

  assign last_beat = !full_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      rd_q     <= 1'b0;
      lat3_q   <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      base_q   <= start_col;
      beat_q   <= '0;
      mask_q   <= len_mask;
      full_q   <= full_page;
      ilv_q    <= interleave;
      rd_q     <= is_read;
      lat3_q   <= lat3;
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_beat) active_q <= 1'b0;
      else           beat_q   <= beat_q + COL_W'(1);
    end
  end

  assign linear_sum  = base_q + beat_q;
  assign col_valid   = active_q;
  assign col_is_read = active_q && rd_q;
  assign col_lat3    = lat3_q;
  assign col_addr    = ilv_q ? (base_q ^ (beat_q & mask_q))
                             : ((base_q & ~mask_q) | (linear_sum & mask_q));
endmodule

// File: rtl/colseq_rd_pipe.sv
module colseq_rd_pipe
  import colseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beat_read,
  input  logic beat_lat3,
  output logic rd_valid
);
  rd_tag_t stg [LAT_MAX+1];

  assign stg[0] = '{live: beat_read, lat3: beat_lat3};

  for (genvar i = 1; i <= LAT_MAX; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '{live: 1'b0, lat3: 1'b0};
      else        stg[i] <= stg[i-1];
    end
  end

  assign rd_valid = (stg[LAT_MIN].live && !stg[LAT_MIN].lat3) ||
                    (stg[LAT_MAX].live &&  stg[LAT_MAX].lat3);
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import colseq_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_code,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             lat3,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_is_read,
  output logic             rd_valid,
  output logic             mode_err
);
  colseq_cmd_e      cmd;
  logic             load, stop;
  logic [COL_W-1:0] len_mask;
  logic             full_page, bad_mode, beat_lat3;

  assign cmd  = colseq_cmd_e'(cmd_code);
  assign load = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign stop = (cmd == CMD_TERM);

  colseq_mode_dec #(.COL_W(COL_W)) dec_i (
    .bl_code(bl_code), .interleave(interleave),
    .len_mask(len_mask), .full_page(full_page), .bad_mode(bad_mode)
  );

  colseq_addr_gen #(.COL_W(COL_W)) gen_i (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
    .start_col(start_col), .len_mask(len_mask), .full_page(full_page),
    .interleave(interleave), .is_read(cmd == CMD_READ), .lat3(lat3),
    .col_valid(col_valid), .col_addr(col_addr),
    .col_is_read(col_is_read), .col_lat3(beat_lat3)
  );

  colseq_rd_pipe pipe_i (
    .clk(clk), .rst_n(rst_n), .beat_read(col_is_read),
    .beat_lat3(beat_lat3), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    mode_err <= 1'b0;
    else if (load) mode_err <= bad_mode;
  end
endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_code,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             interleave,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_is_read,
  input logic             rd_valid,
  input logic             mode_err
);
  logic is_cmd;
  logic undefined_mode;
  assign is_cmd = (cmd_code == 2'b01) || (cmd_code == 2'b10);
  assign undefined_mode = (bl_code[2] && bl_code != 3'b111) ||
                          (bl_code == 3'b111 && interleave);

  assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> col_valid && col_addr == $past(start_col));

  assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'b11 |=> !col_valid);

  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && undefined_mode |=> mode_err);

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && mode_err && cmd_code == 2'b00 |=> !col_valid);

  assert_rd_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(col_is_read, 2) || $past(col_is_read, 3));

  assert_rd_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    col_is_read |-> col_valid);
endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .start_col(start_col),
  .bl_code(bl_code), .interleave(interleave), .col_valid(col_valid),
  .col_addr(col_addr), .col_is_read(col_is_read), .rd_valid(rd_valid),
  .mode_err(mode_err)
);

// File: tb/burst_colseq_tb_top.sv
module burst_colseq_tb_top;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cmd_code = 2'b00;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'b000;
  logic             interleave = 1'b0;
  logic             lat3 = 1'b0;
  logic             col_valid, col_is_read, rd_valid, mode_err;
  logic [COL_W-1:0] col_addr;

  always #10 clk = ~clk;

  burst_colseq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .lat3(lat3),
    .col_valid(col_valid), .col_addr(col_addr), .col_is_read(col_is_read),
    .rd_valid(rd_valid), .mode_err(mode_err)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_active, m_rd, m_il, m_full, m_err, m_l3;
  int m_cnt, m_start, m_bl;
  int cyc = 0;
  bit ring [8];
  bit exp_rd;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int exp_addr();
    if (m_full) return (m_start + m_cnt) % PAGE;
    if (m_il)   return m_start ^ m_cnt;
    return (m_start & ~(m_bl - 1)) | ((m_start + m_cnt) & (m_bl - 1));
  endfunction

  task automatic model_edge();
    bit legal;
    exp_rd = ring[cyc % 8];
    ring[cyc % 8] = 1'b0;
    if (cmd_code == 2'b01 || cmd_code == 2'b10) begin
      legal   = (bl_code <= 3'd3) || (bl_code == 3'd7 && !interleave);
      m_err   = !legal;
      m_full  = legal && bl_code == 3'd7;
      m_bl    = (!legal || m_full) ? 1 : (1 << bl_code);
      m_active = 1'b1; m_cnt = 0; m_start = int'(start_col);
      m_il = interleave; m_rd = (cmd_code == 2'b01); m_l3 = lat3;
    end else if (cmd_code == 2'b11) begin
      m_active = 1'b0;
    end else if (m_active) begin
      if (!m_full && m_cnt == m_bl - 1) m_active = 1'b0;
      else m_cnt = (m_cnt + 1) % PAGE;
    end
    if (m_active && m_rd) ring[(cyc + (m_l3 ? 3 : 2)) % 8] = 1'b1;
    cyc++;
  endtask

  task automatic compare();
    chk(col_valid == m_active, "col_valid", col_valid, m_active);
    if (m_active) begin
      chk(col_addr == exp_addr(), "col_addr", col_addr, exp_addr());
      chk(col_is_read == m_rd, "col_is_read", col_is_read, m_rd);
    end
    chk(rd_valid == exp_rd, "rd_valid", rd_valid, exp_rd);
    chk(mode_err == m_err, "mode_err", mode_err, m_err);
  endtask

  task automatic step(input logic [1:0] c, input int sc, input int blc,
                      input bit il, input bit l3);
    cmd_code = c; start_col = COL_W'(sc); bl_code = 3'(blc);
    interleave = il; lat3 = l3;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cmd_code = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    foreach (ring[i]) ring[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset and just after
    chk(!col_valid && !rd_valid && !mode_err, "reset outputs", col_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); cyc++;
    @(negedge clk);
    chk(!col_valid && !rd_valid && !mode_err, "after reset", col_valid, 0);

    cur_req = "R3";  // linear read BL4 start 6, CL2: 6,7,4,5 (also R2, R5, R10)
    step(2'b01, 6, 2, 0, 0); idle(6);
    cur_req = "R4";  // interleaved read BL8 start 5, CL3
    step(2'b01, 5, 3, 1, 1); idle(8);
    cur_req = "R11"; // write BL2, no read strobe
    step(2'b10, 9, 1, 0, 0); idle(4);
    cur_req = "R5";  // BL1 and BL8 linear
    step(2'b01, 33, 0, 0, 1); idle(4);
    step(2'b10, 13, 3, 0, 0); idle(9);
    cur_req = "R9";  // interrupt mid-burst, back-to-back
    step(2'b01, 20, 3, 0, 0); idle(2);
    step(2'b01, 42, 2, 1, 1);
    step(2'b10, 100, 2, 0, 0); idle(1);
    step(2'b01, 7, 1, 0, 0); idle(6);
    cur_req = "R8";  // terminate mid read with CL3, then terminate while idle
    step(2'b01, 64, 3, 0, 1); idle(2);
    step(2'b11, 0, 0, 0, 0); idle(4);
    step(2'b11, 0, 0, 0, 0); idle(2);
    cur_req = "R6";  // full page across the 511 -> 0 wrap
    step(2'b01, 500, 7, 0, 0); idle(530);
    step(2'b11, 0, 0, 0, 0); idle(4);
    cur_req = "R7";  // undefined modes
    step(2'b01, 17, 7, 1, 0); idle(3);
    step(2'b10, 3, 5, 0, 0); idle(3);
    step(2'b01, 3, 2, 1, 1); idle(5);
    cur_req = "R10"; // latency change between bursts
    step(2'b01, 50, 1, 0, 1);
    step(2'b01, 80, 0, 0, 0); idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule